// File: doc/BRIEF.md
# TDM Synchronous Serial Port

This block is a full-duplex synchronous serial port for audio converters. It drives one serial clock and one frame sync, and it owns two data pins. Each pin is set either to transmit or to receive. Each pin trades parallel words with its own ready/valid stream, and that stream takes the place of a per-pin DMA channel. The serial clock is divided down from the system clock. Serial data changes on the falling serial edge and is captured on the rising serial edge.

In standard mode a frame carries a single word. In multichannel mode a frame carries from 1 to 128 time slots, and a mask decides which of them are active. A transmit pin tri-states its output in an inactive slot, and a receive pin ignores it. Software sets up the frame shape, the word length and the divider while the port is off, then enables the port. Frames then run back to back until the port is disabled again.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset the outputs are idle: `serClkO` and `frameSync` low, `dataOe`, `txReady` and `rxValid` all zero, all error flags zero.
- R2: The serial clock is low when the port is enabled and toggles every `clkDivHalf` system cycles. A full serial period is therefore 2*`clkDivHalf` cycles. Values below 2 act as 2, which keeps the serial clock at no more than a quarter of the system clock.
- R3: `frameSync` is high for exactly one bit period, the one just before bit 0 of slot 0. The first such period follows enable. After that, frame syncs repeat every slots*wordLength bit periods.
- R4: Words go out and come in MSB first. `wordLen` gives the length in bits and is clamped to 8..32. Transmit data changes on the falling serial edge and is sampled on the rising edge.
- R5: In standard mode (`tdmMode`=0) a frame is one word long and `slotMask` has no effect.
- R6: In multichannel mode (`tdmMode`=1) a frame has `slotsM1`+1 slots, and slot s is active when `slotMask[s]`=1. In an inactive slot a transmit pin holds `dataOe` low and takes no word, and a receive pin delivers no word.
- R7: `pinDir[p]`=1 makes pin p a transmitter, which drives `dataOe[p]` high through its active slots. `pinDir[p]`=0 makes it a receiver: its `dataOe[p]` stays low and it captures `dataI[p]`.
- R8: A transmit pin takes one word at the start of each active slot, through a single-cycle `txReady` pulse. If `txValid` is low at that pulse, the slot sends zeros and the sticky `txUnder[p]` flag is set.
- R9: A received word is right-aligned in `rxWord[p]` and is held with `rxValid[p]` until `rxReady[p]` is seen. If a new word finishes while the old one is still pending, the new word is dropped and the sticky `rxOver[p]` flag is set.
- R10: Word length, mode, slot count, divider and pin directions are captured when the port is enabled. Changes to them while it runs have no effect. Disabling the port returns it to idle and clears the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Port runs while high |
| tdmMode | input | 1 | 0 standard, 1 multichannel |
| wordLen | input | 6 | Bits per word, 8..32 |
| slotsM1 | input | 7 | Slots per frame minus one (multichannel) |
| clkDivHalf | input | 8 | System cycles per serial half period |
| slotMask | input | 128 | Bit s enables slot s |
| pinDir | input | 2 | Per pin: 1 transmit, 0 receive |
| serClkO | output | 1 | Serial clock |
| frameSync | output | 1 | Frame sync |
| dataO | output | 2 | Serial data out per pin |
| dataOe | output | 2 | Output enable per pin |
| dataI | input | 2 | Serial data in per pin |
| txWord | input | 2x32 | Transmit word per pin |
| txValid | input | 2 | Transmit word valid |
| txReady | output | 2 | Transmit word taken |
| rxWord | output | 2x32 | Received word per pin |
| rxValid | output | 2 | Received word valid |
| rxReady | input | 2 | Received word accepted |
| txUnder | output | 2 | Sticky transmit underflow |
| rxOver | output | 2 | Sticky receive overflow |

## Verification
Once `enable` is sampled, the frame sync is high from the next cycle. The first rising serial edge comes `clkDivHalf` cycles later. A word taken on a `txReady` pulse is on the pin from the next cycle and stays there for wordLength serial periods, one bit per period. A received word shows up with `rxValid` one cycle after the system edge that samples its last bit on a rising serial edge. The bench samples every output at the falling system edge. It decodes the line only on cycles where the serial clock has just risen, and at those moments data and frame sync are stable for the whole bit. It compares the decoded words and the looped-back received words, in order, against the words it recorded as taken on each ready pulse.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
  localparam int WORD_MAX = 32;
  localparam int LANES    = 2;
  localparam int WLM1_W   = $clog2(WORD_MAX);

  // per-cycle commands from the sequencer to each pin datapath
  typedef struct packed {
    logic              run;
    logic              load;     // first bit of an active slot begins
    logic              idle;     // an inactive slot begins
    logic              shift;    // next bit inside an active slot
    logic              sample;   // rising serial edge inside an active slot
    logic              wordEnd;  // rising edge on the last bit of the word
    logic [WLM1_W-1:0] wlM1;
  } strobe_t;
endpackage

// File: rtl/tdm_port_ctrl.sv
module tdm_port_ctrl
  import tdm_port_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int DIV_W     = 8,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic                 tdmMode,
  input  logic [5:0]           wordLen,
  input  logic [SLOT_W-1:0]    slotsM1,
  input  logic [DIV_W-1:0]     clkDivHalf,
  input  logic [MAX_SLOTS-1:0] slotMask,
  output logic                 serClk,
  output logic                 frameSync,
  output strobe_t              strb
);
  logic run, cfgTdm, sclkR, fsR, leadIn, curActive;
  logic [WLM1_W-1:0] cfgWlM1, bitIdx, nextBit;
  logic [SLOT_W-1:0] cfgSlotsM1, slotIdx, nextSlot, lastSlot;
  logic [DIV_W-1:0]  cfgDiv, divCnt, divClamp;
  logic [5:0]        wlClamp;
  logic tick, fallTick, riseTick, wordDone, slotStart, nextActive, nextIsFrameEnd;

  always_comb begin
    wlClamp  = (wordLen < 6'd8) ? 6'd8 : ((wordLen > 6'd32) ? 6'd32 : wordLen);
    divClamp = (clkDivHalf < DIV_W'(2)) ? DIV_W'(2) : clkDivHalf;
    tick     = run && (divCnt == cfgDiv - 1'b1);
    fallTick = tick && sclkR;
    riseTick = tick && !sclkR;
    lastSlot = cfgTdm ? cfgSlotsM1 : '0;
    wordDone = (bitIdx == cfgWlM1);
    slotStart = fallTick && (leadIn || wordDone);
    if (leadIn)        nextSlot = '0;
    else if (wordDone) nextSlot = (slotIdx == lastSlot) ? '0 : slotIdx + 1'b1;
    else               nextSlot = slotIdx;
    nextBit        = (leadIn || wordDone) ? '0 : bitIdx + 1'b1;
    nextActive     = !cfgTdm || slotMask[nextSlot];
    nextIsFrameEnd = (nextSlot == lastSlot) && (nextBit == cfgWlM1);

    strb.run     = run;
    strb.load    = slotStart && nextActive;
    strb.idle    = slotStart && !nextActive;
    strb.shift   = fallTick && !slotStart && curActive;
    strb.sample  = riseTick && curActive && !leadIn;
    strb.wordEnd = riseTick && curActive && !leadIn && wordDone;
    strb.wlM1    = cfgWlM1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0; cfgTdm <= 1'b0; sclkR <= 1'b0; fsR <= 1'b0;
      leadIn <= 1'b0; curActive <= 1'b0; cfgWlM1 <= '0; bitIdx <= '0;
      cfgSlotsM1 <= '0; slotIdx <= '0; cfgDiv <= DIV_W'(2); divCnt <= '0;
    end else if (!enable) begin
      run <= 1'b0; sclkR <= 1'b0; fsR <= 1'b0;
      leadIn <= 1'b0; curActive <= 1'b0; divCnt <= '0;
    end else if (!run) begin
      run        <= 1'b1;
      cfgTdm     <= tdmMode;
      cfgWlM1    <= WLM1_W'(wlClamp - 6'd1);
      cfgSlotsM1 <= slotsM1;
      cfgDiv     <= divClamp;
      divCnt     <= '0;
      sclkR      <= 1'b0;
      fsR        <= 1'b1;
      leadIn     <= 1'b1;
      bitIdx     <= '0;
      slotIdx    <= '0;
      curActive  <= 1'b0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) sclkR <= !sclkR;
      if (fallTick) begin
        leadIn    <= 1'b0;
        bitIdx    <= nextBit;
        slotIdx   <= nextSlot;
        fsR       <= nextIsFrameEnd;
        curActive <= nextActive;
      end
    end
  end

  assign serClk    = sclkR;
  assign frameSync = fsR;

  // R3
  fs_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fallTick && fsR) |=> !fsR);
  // R2
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable && !tick) |=> $stable(sclkR));
  // R2
  div_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (cfgDiv >= DIV_W'(2) && divCnt < cfgDiv));
  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable) |=> ($stable(cfgDiv) && $stable(cfgSlotsM1) && $stable(cfgWlM1) && $stable(cfgTdm)));
endmodule

// File: rtl/tdm_port_lane.sv
module tdm_port_lane
  import tdm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                isTx,
  input  logic                dataIn,
  input  logic [WORD_MAX-1:0] txWord,
  input  logic                txValid,
  output logic                txReady,
  output logic                dataOut,
  output logic                dataOe,
  output logic [WORD_MAX-1:0] rxWord,
  output logic                rxValid,
  input  logic                rxReady,
  output logic                txUnder,
  output logic                rxOver
);
  logic dirR;
  logic [WORD_MAX-1:0] txSh, rxSh, alignedTx, rxMask, rxNext;

  assign txReady = strb.load && dirR;
  assign dataOut = txSh[WORD_MAX-1];

  always_comb begin
    alignedTx = txWord << (WLM1_W'(WORD_MAX - 1) - strb.wlM1);
    rxMask    = {WORD_MAX{1'b1}} >> (WLM1_W'(WORD_MAX - 1) - strb.wlM1);
    rxNext    = {rxSh[WORD_MAX-2:0], dataIn} & rxMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirR <= 1'b0; dataOe <= 1'b0; txSh <= '0; rxSh <= '0;
      rxWord <= '0; rxValid <= 1'b0; txUnder <= 1'b0; rxOver <= 1'b0;
    end else if (!strb.run) begin
      dirR <= isTx; dataOe <= 1'b0; txSh <= '0;
      rxValid <= 1'b0; txUnder <= 1'b0; rxOver <= 1'b0;
    end else begin
      if (dirR) begin
        if (strb.load) begin
          txSh   <= txValid ? alignedTx : '0;
          dataOe <= 1'b1;
          if (!txValid) txUnder <= 1'b1;
        end else if (strb.idle) begin
          dataOe <= 1'b0;
        end else if (strb.shift) begin
          txSh <= txSh << 1;
        end
      end
      if (!dirR && strb.sample) rxSh <= {rxSh[WORD_MAX-2:0], dataIn};
      if (!dirR && strb.wordEnd) begin
        if (rxValid && !rxReady) rxOver <= 1'b1;
        else begin
          rxWord  <= rxNext;
          rxValid <= 1'b1;
        end
      end else if (rxValid && rxReady) begin
        rxValid <= 1'b0;
      end
    end
  end

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && rxValid && !rxReady) |=> (rxValid && $stable(rxWord)));
  // R9
  over_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && rxOver) |=> rxOver);
  // R8
  under_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && txUnder) |=> txUnder);
  // R7
  rx_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !dirR) |-> !dataOe);
  // R6
  idle_slot_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.idle) |=> !dataOe);
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
  import tdm_port_pkg::*;
#(
  parameter int MAX_SLOTS = 128,
  parameter int DIV_W     = 8,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             enable,
  input  logic                             tdmMode,
  input  logic [5:0]                       wordLen,
  input  logic [SLOT_W-1:0]                slotsM1,
  input  logic [DIV_W-1:0]                 clkDivHalf,
  input  logic [MAX_SLOTS-1:0]             slotMask,
  input  logic [LANES-1:0]                 pinDir,
  output logic                             serClkO,
  output logic                             frameSync,
  output logic [LANES-1:0]                 dataO,
  output logic [LANES-1:0]                 dataOe,
  input  logic [LANES-1:0]                 dataI,
  input  logic [LANES-1:0][WORD_MAX-1:0]   txWord,
  input  logic [LANES-1:0]                 txValid,
  output logic [LANES-1:0]                 txReady,
  output logic [LANES-1:0][WORD_MAX-1:0]   rxWord,
  output logic [LANES-1:0]                 rxValid,
  input  logic [LANES-1:0]                 rxReady,
  output logic [LANES-1:0]                 txUnder,
  output logic [LANES-1:0]                 rxOver
);
  strobe_t strb;

  tdm_port_ctrl #(.MAX_SLOTS(MAX_SLOTS), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tdmMode(tdmMode),
    .wordLen(wordLen), .slotsM1(slotsM1), .clkDivHalf(clkDivHalf),
    .slotMask(slotMask), .serClk(serClkO), .frameSync(frameSync), .strb(strb)
  );

  for (genvar g = 0; g < LANES; g++) begin : gLane
    tdm_port_lane u_lane (
      .clk(clk), .rstN(rstN), .strb(strb), .isTx(pinDir[g]), .dataIn(dataI[g]),
      .txWord(txWord[g]), .txValid(txValid[g]), .txReady(txReady[g]),
      .dataOut(dataO[g]), .dataOe(dataOe[g]), .rxWord(rxWord[g]),
      .rxValid(rxValid[g]), .rxReady(rxReady[g]),
      .txUnder(txUnder[g]), .rxOver(rxOver[g])
    );
  end
endmodule

// File: tb/tdm_serial_port_tb.sv
module tdm_serial_port_tb;
  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0, tdmMode = 1'b0;
  logic [5:0] wordLen = 6'd16;
  logic [6:0] slotsM1 = '0;
  logic [7:0] clkDivHalf = 8'd2;
  logic [127:0] slotMask = '0;
  logic [1:0] pinDir = 2'b01, dataO, dataOe, dataI, txValid = '0, txReady;
  logic [1:0] rxValid, rxReady = 2'b11, txUnder, rxOver;
  logic [1:0][31:0] txWord, rxWord;
  logic serClkO, frameSync;

  always #5 clk = ~clk;

  // each pin loops back into the other
  assign dataI[0] = dataOe[1] & dataO[1];
  assign dataI[1] = dataOe[0] & dataO[0];

  tdm_serial_port u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .tdmMode(tdmMode), .wordLen(wordLen),
    .slotsM1(slotsM1), .clkDivHalf(clkDivHalf), .slotMask(slotMask), .pinDir(pinDir),
    .serClkO(serClkO), .frameSync(frameSync), .dataO(dataO), .dataOe(dataOe),
    .dataI(dataI), .txWord(txWord), .txValid(txValid), .txReady(txReady),
    .rxWord(rxWord), .rxValid(rxValid), .rxReady(rxReady),
    .txUnder(txUnder), .rxOver(rxOver)
  );

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  bit monOn = 0, updPend = 0, started = 0, fsSeen = 0, prevSclk = 0;
  bit cTdm;
  int cWl, cSlots, cDiv, txPin = 0, rxPin = 1;
  logic [127:0] cMask;
  logic [31:0] wlMask, acc;
  int pos, fsGap, fsCount, oeErr, fsErr, periods, cycCnt, lastPeriod;
  logic [31:0] sentQ[$], monQ[$], gotQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] maskFor(input int wl);
    return (wl >= 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 1);
  endfunction

  // transmit source: record what each ready pulse takes
  always @(negedge clk) begin
    if (!monOn) begin
      txWord[0] = $urandom; txWord[1] = $urandom; updPend = 0;
    end else begin
      if (updPend) txWord[txPin] = $urandom;
      updPend = 0;
      if (txReady[txPin]) begin
        sentQ.push_back(txValid[txPin] ? (txWord[txPin] & wlMask) : 32'd0);
        updPend = txValid[txPin];
      end
    end
  end

  // receive sink
  always @(negedge clk)
    if (monOn && rxValid[rxPin] && rxReady[rxPin]) gotQ.push_back(rxWord[rxPin]);

  // line monitor: decode at each rising serial edge
  always @(negedge clk) begin
    if (monOn) begin
      cycCnt++;
      if (serClkO && !prevSclk) begin
        int slot, bitN;
        bit en;
        lastPeriod = cycCnt; cycCnt = 0; periods++;
        if (started) begin
          pos = fsSeen ? 0 : pos + 1;
          slot = pos / cWl; bitN = pos % cWl;
          en = !cTdm || cMask[slot % 128];
          if (dataOe[txPin] != en) oeErr++;
          if (dataOe[rxPin]) oeErr++;
          acc = {acc[30:0], dataO[txPin]};
          if (bitN == cWl - 1 && en) monQ.push_back(acc & wlMask);
          fsGap++;
        end
        if (frameSync) begin
          if (started) begin
            if (fsGap != cSlots * cWl) fsErr++;
            fsCount++;
          end
          started = 1; fsGap = 0;
        end
        fsSeen = frameSync;
      end
      prevSclk = serClkO;
    end
  end

  task automatic startPort(input bit tdm, input int wl, input int sM1, input int dv,
                           input logic [127:0] m, input int tp, input bit txOn, input bit rdy);
    @(negedge clk);
    cTdm = tdm; cWl = (wl < 8) ? 8 : (wl > 32 ? 32 : wl);
    cSlots = tdm ? sM1 + 1 : 1; cDiv = (dv < 2) ? 2 : dv; cMask = m;
    wlMask = maskFor(cWl); txPin = tp; rxPin = 1 - tp;
    tdmMode = tdm; wordLen = 6'(wl); slotsM1 = 7'(sM1); clkDivHalf = 8'(dv);
    slotMask = m; pinDir = (tp == 0) ? 2'b01 : 2'b10;
    txValid = txOn ? ((tp == 0) ? 2'b01 : 2'b10) : 2'b00;
    rxReady = rdy ? 2'b11 : 2'b00;
    sentQ.delete(); monQ.delete(); gotQ.delete();
    started = 0; fsSeen = 0; prevSclk = 0; pos = 0; fsGap = 0; fsCount = 0;
    oeErr = 0; fsErr = 0; periods = 0; cycCnt = 0; lastPeriod = 0; acc = '0;
    monOn = 1; enable = 1;
  endtask

  task automatic stopPort(input string rq, input int minW, input bit chkRx);
    int bad = 0;
    longint a = 0, e = 0;
    monOn = 0; enable = 0;
    repeat (4) @(negedge clk);
    chk(monQ.size() >= minW, rq, "serial words decoded", monQ.size(), minW);
    for (int i = 0; i < monQ.size() && i < sentQ.size(); i++)
      if (monQ[i] != sentQ[i]) begin if (bad == 0) begin a = monQ[i]; e = sentQ[i]; end bad++; end
    chk(bad == 0, rq, "serial word value (MSB first)", a, e);
    if (chkRx) begin
      bad = 0;
      chk(gotQ.size() >= minW - 1, "R9", "received words", gotQ.size(), minW - 1);
      for (int i = 0; i < gotQ.size() && i < sentQ.size(); i++)
        if (gotQ[i] != sentQ[i]) begin if (bad == 0) begin a = gotQ[i]; e = sentQ[i]; end bad++; end
      chk(bad == 0, "R9", "received word value", a, e);
    end
    chk(oeErr == 0, "R6 R7", "output enable per slot/pin mismatches", oeErr, 0);
    chk(fsErr == 0 && fsCount >= 1, "R3", "frame sync spacing errors", fsErr, 0);
    chk(lastPeriod == 2 * cDiv, "R2", "serial clock period", lastPeriod, 2 * cDiv);
  endtask

  initial begin
    logic [127:0] m;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(serClkO == 0 && frameSync == 0, "R1", "clock/sync idle", {serClkO, frameSync}, 0);
    chk(dataOe == 0 && txReady == 0 && rxValid == 0, "R1", "oe/ready/valid idle",
        {dataOe, txReady, rxValid}, 0);
    chk(txUnder == 0 && rxOver == 0, "R1", "flags clear", {txUnder, rxOver}, 0);

    // R5 standard mode, mask all zero yet words flow
    startPort(0, 16, 0, 2, '0, 0, 1, 1);
    repeat (600) @(negedge clk);
    stopPort("R4 R5", 5, 1);

    // R6 multichannel, 5 slots, sparse mask
    startPort(1, 24, 4, 3, 128'b10110, 0, 1, 1);
    repeat (2500) @(negedge clk);
    stopPort("R6", 6, 1);

    // R3 R7 128 slots, pin 1 transmits
    m = {$urandom, $urandom, $urandom, $urandom}; m[0] = 1; m[127] = 1;
    startPort(1, 8, 127, 2, m, 1, 1, 1);
    repeat (9000) @(negedge clk);
    stopPort("R3 R7", 40, 1);

    // R4 32-bit words; R2 divider below minimum acts as 2
    startPort(0, 32, 0, 1, '0, 0, 1, 1);
    repeat (800) @(negedge clk);
    stopPort("R4", 4, 1);

    // R4 word length below 8 clamps to 8
    startPort(0, 5, 0, 2, '0, 1, 1, 1);
    repeat (400) @(negedge clk);
    stopPort("R4", 6, 1);

    // R8 underflow: no valid, zeros sent, sticky flag
    startPort(0, 12, 0, 4, '0, 0, 0, 1);
    repeat (600) @(negedge clk);
    chk(txUnder[0] == 1, "R8", "underflow flag", txUnder[0], 1);
    chk(sentQ.size() >= 2 && sentQ[0] == 0, "R8", "zero word queued", sentQ.size(), 2);
    stopPort("R8", 3, 1);
    chk(txUnder == 0, "R10", "flag cleared by disable", txUnder, 0);

    // R9 overflow: receiver never accepted
    startPort(0, 8, 0, 2, '0, 0, 1, 0);
    repeat (300) @(negedge clk);
    chk(rxValid[1] == 1, "R9", "word held valid", rxValid[1], 1);
    chk(rxWord[1] == sentQ[0], "R9", "first word kept", rxWord[1], sentQ[0]);
    chk(rxOver[1] == 1, "R9", "overflow flag", rxOver[1], 1);
    rxReady = 2'b11;
    repeat (3) @(negedge clk);
    chk(rxOver[1] == 1, "R9", "overflow flag sticky", rxOver[1], 1);
    stopPort("R9", 4, 0);
    chk(rxOver == 0, "R10", "overflow cleared by disable", rxOver, 0);

    // R10 config changed while running has no effect
    startPort(0, 10, 0, 2, '0, 0, 1, 1);
    repeat (40) @(negedge clk);
    clkDivHalf = 8'd7; wordLen = 6'd20; tdmMode = 1; slotsM1 = 7'd3; pinDir = 2'b10;
    repeat (600) @(negedge clk);
    stopPort("R10", 5, 1);

    // constrained random configurations
    for (int k = 0; k < 4; k++) begin
      bit t;
      int wl, s, dv, tp;
      t = 1'($urandom % 2); wl = 8 + int'($urandom % 25); s = int'($urandom % 6);
      dv = 2 + int'($urandom % 3); tp = int'($urandom % 2);
      m = {$urandom, $urandom, $urandom, $urandom}; m[0] = 1;
      startPort(t, wl, s, dv, m, tp, 1, 1);
      repeat ((t ? s + 1 : 1) * wl * 2 * dv * 3 + 100) @(negedge clk);
      stopPort("R4 R6", 2, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "WD", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule